// File: doc/BRIEF.md
# Lithium Cell Charge Supervisor

This block sequences the charge of a single lithium-ion or lithium-polymer cell. Each time an external converter posts a sample, the block reads three fixed-point codes: charger input in millivolts, cell voltage in millivolts and charge current in milliamps. From these it selects a charging phase. The phases are idle, pre-charge for a deeply discharged cell, constant current (CC), constant voltage (CV), done and fault.

The block drives four outputs to the analog charger: a current setpoint code, a charge-enable line, a pre-charge level indication and a fault flag. A separate "full" indicator rises slightly before charging terminates. A safety timer bounds the time spent actively charging. Independently of the phase, the cell voltage on every sample is also converted to a zero-to-four bar level.

Every threshold crossing that advances the phase must be seen on several consecutive samples before it is acted on, which rejects noise. Loss of the charger is the exception. It is acted on at the first sample that shows it.

Top module: `chg_supervisor`

## Requirements
- R1: After reset the state output is 0 (idle), and chg_en, iset_ma, pre_lvl, full, fault and bars are all zero.
- R2: In idle, a run of DEB consecutive valid samples (default 4) with vin_mv >= 4800 starts a charge. The charge enters pre-charge (state 1) if vbat_mv < 3000 on the qualifying sample, and constant current (state 2) otherwise. A shorter run leaves the block in idle.
- R3: In pre-charge, chg_en is 1 and iset_ma is 100 when pre_sel was 1 on entry, or 50 when it was 0. pre_lvl equals that captured choice. After DEB consecutive valid samples with vbat_mv >= 3000, the block moves to constant current.
- R4: In constant current (state 2), chg_en is 1 and iset_ma is 645. After DEB consecutive valid samples with vbat_mv >= 4200, the block moves to constant voltage (state 3), keeping iset_ma at 645.
- R5: In constant voltage, full rises after DEB consecutive valid samples with ibat_ma <= 110, and the state stays 3 while ibat_ma > 105.
- R6: In constant voltage, DEB consecutive valid samples with ibat_ma <= 105 move the block to done (state 4). In done, chg_en is 0, iset_ma is 0 and full is 1.
- R7: In any state, a single valid sample with vin_mv < 4800 returns the block to idle at that sample. The safety timer is cleared, so a later charge gets the full time limit again.
- R8: When the time spent in states 1 to 3 reaches TICK_DIV*TIMEOUT_TICKS clock cycles, the block goes from constant voltage to done, or from pre-charge or constant current to fault (state 5). In fault, fault is 1 and chg_en is 0, and the block holds there until the charger is removed.
- R9: On each valid sample, bars becomes 4 for vbat_mv >= 3740, 3 for 3650..3739, 2 for 3590..3649, 1 for 3350..3589, and 0 below 3350.
- R10: A valid sample that fails a threshold restarts that threshold's consecutive-sample count from zero.
- R11: Cycles with smp_valid low have no effect on state, on qualification counts or on bars, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| vin_mv | input | 16 | Charger input voltage, mV |
| vbat_mv | input | 16 | Cell voltage, mV |
| ibat_ma | input | 16 | Charge current, mA |
| pre_sel | input | 1 | Requested pre-charge level (1 = high), captured on entry to pre-charge |
| iset_ma | output | 16 | Current setpoint code, mA |
| chg_en | output | 1 | Charge path enable |
| pre_lvl | output | 1 | High pre-charge level in use |
| full | output | 1 | Cell-full indicator |
| fault | output | 1 | Timeout fault flag |
| bars | output | 3 | Battery level, 0 to 4 |
| state | output | 3 | Phase: 0 idle, 1 pre, 2 CC, 3 CV, 4 done, 5 fault |

## Verification
The bench keeps every voltage and current threshold at its default and the consecutive-sample count at 4. This makes every qualification run, and every break in one, a short directed sequence of samples. The timer is built with TICK_DIV = 4 and TIMEOUT_TICKS = 60, so the charge-time limit falls at 240 active cycles instead of two hours. That brings the timeout exits from constant current and from constant voltage within a few hundred cycles. It also brings within reach the check that removing the charger really clears the timer: a second charge must survive past the point where an uncleared count would already have expired.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int MW    = 16;
    localparam int BAR_W = 3;

    typedef logic [MW-1:0] code_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_CC    = 3'd2,
        ST_CV    = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } chg_state_e;

    typedef struct packed {
        code_t vin;
        code_t vbat;
        code_t ibat;
    } chg_sample_t;

    // qualified threshold indices
    localparam int Q_VIN  = 0;
    localparam int Q_PRE  = 1;
    localparam int Q_CV   = 2;
    localparam int Q_FULL = 3;
    localparam int Q_TERM = 4;
    localparam int NQ     = 5;

    // level band lower edges, mV
    localparam int LVL4_MV = 3740;
    localparam int LVL3_MV = 3650;
    localparam int LVL2_MV = 3590;
    localparam int LVL1_MV = 3350;

    function automatic logic [BAR_W-1:0] bars_of(code_t mv);
        if (mv >= code_t'(LVL4_MV))      return BAR_W'(4);
        else if (mv >= code_t'(LVL3_MV)) return BAR_W'(3);
        else if (mv >= code_t'(LVL2_MV)) return BAR_W'(2);
        else if (mv >= code_t'(LVL1_MV)) return BAR_W'(1);
        else                             return BAR_W'(0);
    endfunction

    function automatic logic is_charging(chg_state_e s);
        return (s == ST_PRE) || (s == ST_CC) || (s == ST_CV);
    endfunction

endpackage

// File: rtl/chg_qual.sv
module chg_qual #(
    parameter int DEB = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic cond,
    output logic hit
);
    localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;
    localparam logic [CW-1:0] TOP = CW'(DEB - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (valid) begin
            if (!cond)
                run_cnt <= '0;
            else if (run_cnt != TOP)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // fires on the DEB-th consecutive qualifying sample and after
    assign hit = valid && cond && (run_cnt == TOP);

endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
    parameter int TICK_DIV = 26_000_000,
    parameter int LIMIT    = 7200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] P_TOP = PW'(TICK_DIV - 1);
    localparam logic [TW-1:0] T_TOP = TW'(LIMIT);

    logic [PW-1:0] presc;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc <= '0;
            ticks <= '0;
        end else if (ticks != T_TOP) begin
            if (presc == P_TOP) begin
                presc <= '0;
                ticks <= ticks + 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

    assign expired = (ticks == T_TOP);

endmodule

// File: rtl/chg_level.sv
module chg_level
    import chg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  code_t            vbat,
    output logic [BAR_W-1:0] bars
);
    always_ff @(posedge clk) begin
        if (rst)
            bars <= '0;
        else if (valid)
            bars <= bars_of(vbat);
    end
endmodule

// File: rtl/chg_supervisor.sv
module chg_supervisor
    import chg_pkg::*;
#(
    parameter int DEB           = 4,
    parameter int VIN_DET_MV    = 4800,
    parameter int PRE_MV        = 3000,
    parameter int CV_MV         = 4200,
    parameter int FULL_MA       = 110,
    parameter int TERM_MA       = 105,
    parameter int CC_MA         = 645,
    parameter int PRE_LO_MA     = 50,
    parameter int PRE_HI_MA     = 100,
    parameter int TICK_DIV      = 26_000_000,
    parameter int TIMEOUT_TICKS = 7200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_valid,
    input  logic [chg_pkg::MW-1:0] vin_mv,
    input  logic [chg_pkg::MW-1:0] vbat_mv,
    input  logic [chg_pkg::MW-1:0] ibat_ma,
    input  logic                   pre_sel,
    output logic [chg_pkg::MW-1:0] iset_ma,
    output logic                   chg_en,
    output logic                   pre_lvl,
    output logic                   full,
    output logic                   fault,
    output logic [2:0]             bars,
    output logic [2:0]             state
);
    chg_sample_t smp;
    logic [NQ-1:0] cond;
    logic [NQ-1:0] hit;
    logic          unplug;
    logic          expired;
    logic          run;
    chg_state_e    st, st_nx;
    logic          pre_hi_q;
    logic          full_q;

    assign smp = '{vin: vin_mv, vbat: vbat_mv, ibat: ibat_ma};

    always_comb begin
        cond         = '0;
        cond[Q_VIN]  = smp.vin  >= code_t'(VIN_DET_MV);
        cond[Q_PRE]  = smp.vbat >= code_t'(PRE_MV);
        cond[Q_CV]   = smp.vbat >= code_t'(CV_MV);
        cond[Q_FULL] = smp.ibat <= code_t'(FULL_MA);
        cond[Q_TERM] = smp.ibat <= code_t'(TERM_MA);
    end

    generate
        for (genvar gi = 0; gi < NQ; gi++) begin : g_qual
            chg_qual #(.DEB(DEB)) u_q (
                .clk   (clk),
                .rst   (rst),
                .valid (smp_valid),
                .cond  (cond[gi]),
                .hit   (hit[gi])
            );
        end
    endgenerate

    assign unplug = smp_valid && !cond[Q_VIN];
    assign run    = is_charging(st);

    chg_timer #(.TICK_DIV(TICK_DIV), .LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .expired (expired)
    );

    chg_level u_level (
        .clk   (clk),
        .rst   (rst),
        .valid (smp_valid),
        .vbat  (smp.vbat),
        .bars  (bars)
    );

    // next-phase selection; charger removal outranks everything
    always_comb begin
        st_nx = st;
        if (unplug) begin
            st_nx = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (hit[Q_VIN]) st_nx = cond[Q_PRE] ? ST_CC : ST_PRE;
                ST_PRE:   if (expired) st_nx = ST_FAULT;
                          else if (hit[Q_PRE]) st_nx = ST_CC;
                ST_CC:    if (expired) st_nx = ST_FAULT;
                          else if (hit[Q_CV]) st_nx = ST_CV;
                ST_CV:    if (expired || hit[Q_TERM]) st_nx = ST_DONE;
                ST_DONE:  st_nx = ST_DONE;
                ST_FAULT: st_nx = ST_FAULT;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pre_hi_q <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && st_nx == ST_PRE)
                pre_hi_q <= pre_sel;
            if (st_nx != ST_CV)
                full_q <= 1'b0;
            else if (st == ST_CV && hit[Q_FULL])
                full_q <= 1'b1;
        end
    end

    always_comb begin
        case (st)
            ST_PRE:       iset_ma = pre_hi_q ? code_t'(PRE_HI_MA) : code_t'(PRE_LO_MA);
            ST_CC, ST_CV: iset_ma = code_t'(CC_MA);
            default:      iset_ma = '0;
        endcase
    end

    assign chg_en  = run;
    assign pre_lvl = (st == ST_PRE) && pre_hi_q;
    assign full    = full_q || (st == ST_DONE);
    assign fault   = (st == ST_FAULT);
    assign state   = st;

endmodule

// File: rtl/chg_supervisor_chk.sv
module chg_supervisor_chk #(
    parameter int VIN_DET_MV = 4800,
    parameter int CC_MA      = 645
) (
    input logic        clk,
    input logic        rst,
    input logic        smp_valid,
    input logic [15:0] vin_mv,
    input logic [15:0] iset_ma,
    input logic        chg_en,
    input logic        full,
    input logic        fault,
    input logic [2:0]  bars,
    input logic [2:0]  state
);
    // R7
    removal_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && vin_mv < 16'(VIN_DET_MV)) |=> (state == 3'd0));

    // R6
    done_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd4) |-> (!chg_en && full && iset_ma == 16'd0));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd5 && !(smp_valid && vin_mv < 16'(VIN_DET_MV))) |=> (state == 3'd5 && fault));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && (state == 3'd0 || state == 3'd4)) |=> $stable(state));

    // R11
    bars_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(bars));

    // R4
    cc_setpoint_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd2) |-> (chg_en && iset_ma == 16'(CC_MA)));

    // R9
    bars_range_chk: assert property (@(posedge clk) disable iff (rst)
        bars <= 3'd4);
endmodule

bind chg_supervisor chg_supervisor_chk #(
    .VIN_DET_MV (VIN_DET_MV),
    .CC_MA      (CC_MA)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .vin_mv    (vin_mv),
    .iset_ma   (iset_ma),
    .chg_en    (chg_en),
    .full      (full),
    .fault     (fault),
    .bars      (bars),
    .state     (state)
);

// File: tb/chg_supervisor_test.sv
module chg_supervisor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] vin_mv = '0;
    logic [15:0] vbat_mv = '0;
    logic [15:0] ibat_ma = '0;
    logic        pre_sel = 1'b0;
    logic [15:0] iset_ma;
    logic        chg_en, pre_lvl, full, fault;
    logic [2:0]  bars, state;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    chg_supervisor #(.TICK_DIV(4), .TIMEOUT_TICKS(60)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .vin_mv(vin_mv), .vbat_mv(vbat_mv), .ibat_ma(ibat_ma),
        .pre_sel(pre_sel), .iset_ma(iset_ma), .chg_en(chg_en),
        .pre_lvl(pre_lvl), .full(full), .fault(fault),
        .bars(bars), .state(state)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one valid sample; returns at the negedge after it is taken
    task automatic sample(input int vi, input int vb, input int ib);
        vin_mv = 16'(vi); vbat_mv = 16'(vb); ibat_ma = 16'(ib);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic samples(input int n, input int vi, input int vb, input int ib);
        for (int i = 0; i < n; i++) sample(vi, vb, ib);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", state, 0);
        check("R1 chg_en", chg_en, 0);
        check("R1 iset", iset_ma, 0);
        check("R1 flags", {pre_lvl, full, fault}, 0);
        check("R1 bars", bars, 0);
    endtask

    task automatic t_main_path();
        do_reset();
        pre_sel = 1'b1;
        samples(3, 5000, 2800, 0);
        check("R2 short run idle", state, 0);
        sample(5000, 2800, 0);
        check("R2 enter pre", state, 1);
        check("R3 iset hi", iset_ma, 100);
        check("R3 pre_lvl", pre_lvl, 1);
        check("R3 chg_en", chg_en, 1);
        samples(3, 5000, 3100, 300);
        sample(5000, 2900, 300);
        samples(3, 5000, 3100, 300);
        check("R10 interrupted pre run", state, 1);
        sample(5000, 3100, 300);
        check("R3 pre to cc", state, 2);
        check("R4 iset cc", iset_ma, 645);
        samples(3, 5000, 4200, 645);
        check("R4 still cc", state, 2);
        sample(5000, 4200, 645);
        check("R4 enter cv", state, 3);
        check("R4 iset cv", iset_ma, 645);
        samples(3, 5000, 4200, 108);
        check("R5 full not yet", full, 0);
        sample(5000, 4200, 108);
        check("R5 full set", full, 1);
        check("R5 stays cv", state, 3);
        samples(3, 5000, 4200, 105);
        check("R6 not yet done", state, 3);
        sample(5000, 4200, 105);
        check("R6 done", state, 4);
        check("R6 done outputs", {chg_en, full}, 2'b01);
        check("R6 iset zero", iset_ma, 0);
        sample(4700, 4200, 0);
        check("R7 removal from done", state, 0);
    endtask

    task automatic t_pre_low_and_quiet();
        do_reset();
        pre_sel = 1'b0;
        samples(3, 5000, 2800, 0);
        vin_mv = 0; vbat_mv = 4300; ibat_ma = 999;
        repeat (3) @(negedge clk);
        check("R11 invalid ignored state", state, 0);
        check("R11 invalid ignored bars", bars, 0);
        sample(5000, 2800, 0);
        check("R11 count kept, pre", state, 1);
        check("R3 iset lo", iset_ma, 50);
        check("R3 pre_lvl lo", pre_lvl, 0);
        samples(4, 5000, 3500, 0);
        check("R3 cc", state, 2);
        vin_mv = 0;
        repeat (3) @(negedge clk);
        check("R11 unstrobed removal ignored", state, 2);
        sample(0, 3500, 0);
        check("R7 removal from cc", state, 0);
        check("R7 chg_en off", chg_en, 0);
    endtask

    task automatic t_timeout_cc();
        do_reset();
        samples(4, 5000, 3500, 645);
        check("R2 direct cc", state, 2);
        repeat (226) @(negedge clk);
        check("R8 before limit", state, 2);
        repeat (30) @(negedge clk);
        check("R8 cc timeout fault", state, 5);
        check("R8 fault flags", {fault, chg_en}, 2'b10);
        samples(2, 5000, 3500, 0);
        check("R8 fault holds", state, 5);
        sample(1000, 3500, 0);
        check("R7 removal from fault", state, 0);
        check("R7 fault clear", fault, 0);
        samples(4, 5000, 3500, 645);
        repeat (226) @(negedge clk);
        check("R7 timer cleared", state, 2);
    endtask

    task automatic t_timeout_cv();
        do_reset();
        samples(4, 5000, 3500, 645);
        samples(4, 5000, 4200, 645);
        check("R4 cv reached", state, 3);
        ibat_ma = 500;
        repeat (260) @(negedge clk);
        check("R8 cv timeout done", state, 4);
        check("R8 full after cv timeout", full, 1);
    endtask

    task automatic t_level();
        do_reset();
        sample(0, 4300, 0); check("R9 4300", bars, 4);
        sample(0, 3740, 0); check("R9 3740", bars, 4);
        sample(0, 3739, 0); check("R9 3739", bars, 3);
        sample(0, 3650, 0); check("R9 3650", bars, 3);
        sample(0, 3649, 0); check("R9 3649", bars, 2);
        sample(0, 3590, 0); check("R9 3590", bars, 2);
        sample(0, 3589, 0); check("R9 3589", bars, 1);
        sample(0, 3350, 0); check("R9 3350", bars, 1);
        sample(0, 3349, 0); check("R9 3349", bars, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_main_path();
        t_pre_low_and_quiet();
        t_timeout_cc();
        t_timeout_cv();
        t_level();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule